// File: doc/BRIEF.md
# FFT Bin Order Restorer

This block sits behind a streaming FFT whose results leave in bit-reversed bin order. It puts each frame back into natural frequency order: samples are written into a frame memory at consecutive addresses and are then read out with the address bits mirrored. Two frame banks take turns, so one frame can fill while the previous one drains and frames can follow each other with no gap.

A pass-through control lets frames leave unchanged, still in bit-reversed order and with no buffering delay. This suits a next stage, such as an inverse transform, that accepts that order, as long as every operand it combines uses the same order. The control is sampled only at the start of an input frame. Both ports carry one sample per valid/ready handshake. The output marks the final sample of each frame. The frame length is a power-of-two parameter.

Top module: `fft_bin_reorder`

## Requirements
- R1: While reset is applied, and for the two cycles after it is released, out_valid and in_ready are low. After that, with both banks empty and the pass-through control low, in_ready is high and out_valid is low.
- R2: In reorder mode, output sample k of a frame is the input sample at position rev(k), where rev mirrors the log2(FRAME_LEN) index bits. For FRAME_LEN = 8 the input positions come out in the order 0, 4, 2, 6, 1, 5, 3, 7.
- R3: Whenever out_valid is high, out_last is high exactly on the FRAME_LEN-th output sample of a frame, and low on every other sample.
- R4: With out_ready held high in reorder mode, two frames sent back to back are accepted in 2*FRAME_LEN consecutive cycles with no stall: one bank fills while the other drains.
- R5: When both banks hold frames that have not been read, in_ready is low.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value in the next cycle.
- R7: In reorder mode no output appears before a frame is complete. The first sample of a frame becomes valid in the cycle after the frame's last input sample is accepted.
- R8: In pass-through mode, out_valid equals in_valid, out_data equals in_data and in_ready equals out_ready in the same cycle. Samples keep their arrival order.
- R9: The pass-through control is sampled only when an input frame starts. Changing it partway through a frame has no effect on that frame.
- R10: A pass-through frame is held off (in_ready low) until every buffered reordered frame has been read. It then streams through directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | 1 = pass the next frame through in bit-reversed order |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts the input sample |
| in_data | input | DATA_W | Input sample, arriving in bit-reversed bin order |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | DATA_W | Output sample |
| out_last | output | 1 | Marks the final sample of a frame |

## Verification
The bench builds the block with FRAME_LEN = 8 and DATA_W = 16. With frames this short, the full mirror order can be checked by hand and both banks can be filled within a few dozen cycles. This makes it cheap to reach the both-banks-full hold-off, output stalls, a pass-through request arriving mid-frame, and the drain that must finish before a pass-through frame may start. It also lets the bench switch between the two modes several times in one run.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic {PATH_REORDER = 1'b0, PATH_PASS = 1'b1} path_e;
  localparam int unsigned BANKS = 2;
endpackage

// File: rtl/fbr_bank_store.sv
module fbr_bank_store #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] bank_word [fbr_pkg::BANKS];

  for (genvar g = 0; g < fbr_pkg::BANKS; g++) begin : g_bank
    logic [DW-1:0] cells [DEPTH];
    logic          sel_w;
    assign sel_w = wr_en && (int'(wr_bank) == g);
    always_ff @(posedge clk) begin
      if (sel_w) cells[wr_addr] <= wr_data;
    end
    assign bank_word[g] = cells[rd_addr];
  end

  assign rd_data = bank_word[rd_bank];
endmodule

// File: rtl/fbr_wr_ctrl.sv
module fbr_wr_ctrl
  import fbr_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          in_valid,
  input  logic          bypass_req,
  input  logic [1:0]    bank_full,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic          frame_done,
  output logic          pass_act,
  output logic          pass_last
);
  localparam logic [AW-1:0] LAST = '1;

  logic [AW-1:0] cnt_q, cnt_d;
  logic          sel_q, sel_d;
  path_e         mode_q, mode_d, cur_mode;
  logic          at_start, take;

  always_comb begin
    at_start   = (cnt_q == '0);
    cur_mode   = at_start ? (bypass_req ? PATH_PASS : PATH_REORDER) : mode_q;
    pass_act   = run && (cur_mode == PATH_PASS) && (bank_full == 2'b00);
    in_ready   = pass_act ? out_ready
                          : (run && (cur_mode == PATH_REORDER) && !bank_full[sel_q]);
    take       = in_valid && in_ready;
    wr_en      = take && (cur_mode == PATH_REORDER);
    frame_done = wr_en && (cnt_q == LAST);
    wr_bank    = sel_q;
    wr_addr    = cnt_q;
    pass_last  = (cnt_q == LAST);
    cnt_d      = cnt_q + 1'b1;
    mode_d     = at_start ? cur_mode : mode_q;
    sel_d      = frame_done ? ~sel_q : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      mode_q <= PATH_REORDER;
    end else if (take) begin
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/fbr_rd_ctrl.sv
module fbr_rd_ctrl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    bank_full,
  input  logic          pass_act,
  input  logic          out_ready,
  output logic          rd_valid,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          rd_last,
  output logic          frame_read
);
  localparam logic [AW-1:0] LAST = '1;

  logic [AW-1:0] cnt_q, cnt_d;
  logic          sel_q, sel_d;
  logic          take;

  for (genvar b = 0; b < AW; b++) begin : g_mirror
    assign rd_addr[b] = cnt_q[AW-1-b];
  end

  always_comb begin
    rd_valid   = run && !pass_act && bank_full[sel_q];
    take       = rd_valid && out_ready;
    rd_last    = (cnt_q == LAST);
    frame_read = take && rd_last;
    rd_bank    = sel_q;
    cnt_d      = cnt_q + 1'b1;
    sel_d      = frame_read ? ~sel_q : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/fft_bin_reorder.sv
module fft_bin_reorder
  import fbr_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FRAME_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  localparam int unsigned AW = $clog2(FRAME_LEN);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  logic [1:0]        bank_full, bank_full_d;
  logic              wr_en, wr_bank, frame_done, pass_act, pass_last;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic              rd_valid, rd_bank, rd_last, frame_read;
  logic [DATA_W-1:0] rd_data;

  fbr_wr_ctrl #(.AW(AW)) u_wr (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .run        (core_rst_n),
    .in_valid   (in_valid),
    .bypass_req (bypass),
    .bank_full  (bank_full),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .wr_en      (wr_en),
    .wr_bank    (wr_bank),
    .wr_addr    (wr_addr),
    .frame_done (frame_done),
    .pass_act   (pass_act),
    .pass_last  (pass_last)
  );

  fbr_rd_ctrl #(.AW(AW)) u_rd (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .run        (core_rst_n),
    .bank_full  (bank_full),
    .pass_act   (pass_act),
    .out_ready  (out_ready),
    .rd_valid   (rd_valid),
    .rd_bank    (rd_bank),
    .rd_addr    (rd_addr),
    .rd_last    (rd_last),
    .frame_read (frame_read)
  );

  fbr_bank_store #(.DW(DATA_W), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_bank (wr_bank),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .rd_bank (rd_bank),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // occupancy: set by a completed write frame, cleared by a completed read frame
  always_comb begin
    for (int b = 0; b < 2; b++) begin
      bank_full_d[b] = (bank_full[b] || (frame_done && (int'(wr_bank) == b)))
                       && !(frame_read && (int'(rd_bank) == b));
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) bank_full <= 2'b00;
    else             bank_full <= bank_full_d;
  end

  always_comb begin
    if (pass_act) begin
      out_valid = in_valid;
      out_data  = in_data;
      out_last  = pass_last;
    end else begin
      out_valid = rd_valid;
      out_data  = rd_data;
      out_last  = rd_last;
    end
  end
endmodule

// File: rtl/fbr_checker.sv
module fbr_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned N  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_last,
  input logic [1:0]    bank_full,
  input logic          pass_act
);
  localparam int unsigned AW = $clog2(N);

  logic [AW-1:0] ocnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ocnt_q <= '0;
    else if (out_valid && out_ready) ocnt_q <= ocnt_q + 1'b1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
  AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (ocnt_q == AW'(N-1)))); // R3
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_full == 2'b11) |-> !in_ready); // R5
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    pass_act |-> ((out_valid == in_valid) && (in_ready == out_ready))); // R8
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_full == 2'b00) && !pass_act) |-> !out_valid); // R7
endmodule

bind fft_bin_reorder fbr_checker #(.DW(DATA_W), .N(FRAME_LEN)) u_fbr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .bank_full (bank_full),
  .pass_act  (pass_act)
);

// File: tb/fft_bin_reorder_test.sv
`timescale 1ns/100ps
module fft_bin_reorder_test;
  localparam int unsigned W = 16;
  localparam int unsigned N = 8;

  // {stimulus, expected output at the same sequence position}
  localparam logic [31:0] VEC [0:15] = '{
    32'h0100_0100, 32'h0101_0104, 32'h0102_0102, 32'h0103_0106,
    32'h0104_0101, 32'h0105_0105, 32'h0106_0103, 32'h0107_0107,
    32'h00A0_00A0, 32'h00B1_00E4, 32'h00C2_00C2, 32'h00D3_0016,
    32'h00E4_00B1, 32'h00F5_00F5, 32'h0016_00D3, 32'h0027_0027
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bypass = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;
  logic         out_last;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  fft_bin_reorder #(.DATA_W(W), .FRAME_LEN(N)) uut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  function automatic int rev3(input int k);
    int r = 0;
    for (int b = 0; b < 3; b++) if (k[b]) r |= 1 << (2 - b);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // both tasks are entered on a falling edge
  task automatic push(input logic [W-1:0] d);
    bit ok;
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      #1 ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic pop(input logic [W-1:0] exp, input bit exp_last, input string tag);
    bit ok;
    out_ready = 1'b1;
    forever begin
      #1 ok = out_valid;
      if (ok) begin
        chk({tag, " data"}, 32'(out_data), 32'(exp));
        chk({tag, " last"}, 32'(out_last), 32'(exp_last));
      end
      @(negedge clk);
      if (ok) break;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    time t0;
    // R1 reset state
    @(negedge clk);
    chk("R1 valid in reset", 32'(out_valid), 0);
    chk("R1 ready in reset", 32'(in_ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ready after reset", 32'(in_ready), 1);
    chk("R1 valid after reset", 32'(out_valid), 0);
    @(negedge clk);

    // R2 R3 R4: table walk, two frames streamed back to back
    t0 = $time;
    fork
      begin
        for (int i = 0; i < 16; i++) push(VEC[i][31:16]);
        chk("R4 input cycles", 32'(($time - t0) / 5), 16);
      end
      begin
        for (int i = 0; i < 16; i++) pop(VEC[i][15:0], (i % 8) == 7, "R2 R3 table");
      end
    join
    out_ready = 1'b0;

    // R5 both banks full, then R6 stall hold
    for (int i = 0; i < 16; i++) push(W'(16'h0200 + i));
    #1;
    chk("R5 ready with both full", 32'(in_ready), 0);
    chk("R6 valid under stall", 32'(out_valid), 1);
    held = out_data;
    repeat (3) @(negedge clk);
    #1;
    chk("R6 data held", 32'(out_data), 32'(held));
    chk("R6 valid held", 32'(out_valid), 1);
    @(negedge clk);
    for (int k = 0; k < 16; k++)
      pop(W'(16'h0200 + 8 * (k / 8) + rev3(k % 8)), (k % 8) == 7, "R2 R5 drain");
    out_ready = 1'b0;

    // R7 no output before the frame is complete
    for (int i = 0; i < 7; i++) push(W'(16'h0300 + i));
    #1;
    chk("R7 no early valid", 32'(out_valid), 0);
    @(negedge clk);
    push(W'(16'h0307));
    #1;
    chk("R7 valid after last", 32'(out_valid), 1);
    chk("R7 first sample", 32'(out_data), 32'h0300);
    @(negedge clk);
    for (int k = 0; k < 8; k++) pop(W'(16'h0300 + rev3(k)), k == 7, "R7 frame");

    // R8 pass-through
    bypass = 1'b1;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1;
      in_data  = W'(16'h0400 + i);
      if (i == 3) begin
        out_ready = 1'b0;
        #1;
        chk("R8 ready follows out_ready", 32'(in_ready), 0);
        chk("R8 valid follows in_valid", 32'(out_valid), 1);
        @(negedge clk);
        out_ready = 1'b1;
      end
      #1;
      chk("R8 valid", 32'(out_valid), 1);
      chk("R8 data", 32'(out_data), 32'(16'h0400 + i));
      chk("R8 last", 32'(out_last), 32'(i == 7));
      chk("R8 ready", 32'(in_ready), 1);
      @(negedge clk);
    end
    in_valid = 1'b0;

    // R9 mid-frame change ignored, R10 hold-off until drained
    bypass = 1'b0;
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) push(W'(16'h0500 + i));
    bypass = 1'b1;
    for (int i = 3; i < 8; i++) push(W'(16'h0500 + i));
    #1;
    chk("R10 held off while buffered", 32'(in_ready), 0);
    chk("R9 frame still reordered", 32'(out_data), 32'h0500);
    @(negedge clk);
    for (int k = 0; k < 8; k++) pop(W'(16'h0500 + rev3(k)), k == 7, "R9 frame");
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1;
      in_data  = W'(16'h0600 + i);
      #1;
      chk("R10 pass ready", 32'(in_ready), 1);
      chk("R10 pass data", 32'(out_data), 32'(16'h0600 + i));
      chk("R10 pass last", 32'(out_last), 32'(i == 7));
      @(negedge clk);
    end
    in_valid = 1'b0;
    bypass = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule